// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory

This block is a pipelined memory split into several independent banks, with consecutive word addresses spread across them. The low address bits pick a bank and the remaining bits pick a row inside that bank. Each bank takes a fixed number of cycles to serve one access. While one bank is serving an access, the other banks can accept new ones. A requester that issues consecutive addresses on consecutive cycles therefore keeps every bank busy in turn and receives one word per cycle once the pipeline has filled.

Requests arrive on a valid/ready port, at most one per cycle. A request aimed at a bank that is still serving an earlier access holds ready low until that bank is free. Reads are tagged when they are accepted. Their data passes through a small reorder store, so responses leave on the valid data port strictly in the order the reads were accepted. Writes obey the same bank and busy rules but never produce a response.

Top module: `ilv_mem`

## Requirements
- R1: The bank index is `req_addr[log2(BANKS)-1:0]` and the row inside the bank is the remaining upper address bits. Two addresses that differ only in their upper bits use the same bank, and two addresses that differ in their low bits use different banks.
- R2: A read accepted at clock edge t presents its response (`rsp_valid` high) in the cycle that follows edge t+LAT+1.
- R3: After a bank accepts a read or a write at edge t, a request to that same bank sees `req_ready` low until edge t+LAT, which is the first edge at which it can be accepted. `req_ready` depends only on whether the addressed bank is busy.
- R4: Each read returns the data of the most recent write to the same address that was accepted before it. Responses come out in the order the reads were accepted.
- R5: A write produces no response.
- R6: A stream of consecutive addresses presented on every cycle is accepted without any stall and returns one word per cycle in steady state.
- R7: A stream with a stride equal to BANKS is accepted once every LAT cycles, and its responses are spaced LAT cycles apart.
- R8: In the first cycle after a synchronous reset, `rsp_valid` is low and `req_ready` is high.
- R9: At most one bank completes a read in any cycle, and the reorder store never holds more reads than it has slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can accept the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low bits select the bank |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, registered |
| rsp_data | output | DATA_W | Read data, registered, in acceptance order |

## Verification
The bench builds the block with 8 banks, a 4-cycle bank latency, 8-bit addresses and 32-bit data. With these values the full address space can be filled and read back, the conflict stall of LAT-1 cycles is long enough to count, and a stride-8 stream falls into a single bank. Random traffic then mixes same-bank conflicts with bank-parallel overlap. In that traffic the reorder store holds up to LAT+1 reads, so its wrap-around is exercised many times.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  // Life cycle of one reorder slot
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_DONE = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ilv_mem_bank.sv
module ilv_mem_bank #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  tag_in,
  output logic              busy,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_data
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_q;
  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic [TAG_W-1:0]  tag_q;

  // Storage port written so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (start) begin
      if (wr) mem[row] <= wdata;
      else    rd_q     <= mem[row];
    end
  end

  // Access timer: busy for LAT-1 cycles after the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= 1'b0;
      tag_q <= '0;
    end else if (start) begin
      cnt   <= CNT_W'(LAT - 1);
      pend  <= !wr;
      tag_q <= tag_in;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (done)      pend <= 1'b0;
    end
  end

  assign busy      = (cnt != '0);
  assign done      = pend && (cnt == '0);
  assign done_tag  = tag_q;
  assign done_data = rd_q;

  // R3: a bank is never started while it is still serving an access
  assert_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R5: a write never leads to a completion
  assert_wr_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (start && wr) |=> !done);
endmodule

// File: rtl/ilv_mem_steer.sv
module ilv_mem_steer #(
  parameter int ADDR_W = 8,
  parameter int BANKS  = 8,
  parameter int BSEL_W = 3,
  parameter int ROW_W  = 5
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANKS-1:0]  busy,
  output logic              req_ready,
  output logic [BANKS-1:0]  start,
  output logic [ROW_W-1:0]  row
);
  logic [BSEL_W-1:0] bsel;

  assign bsel      = req_addr[BSEL_W-1:0];
  assign row       = req_addr[ADDR_W-1:BSEL_W];
  assign req_ready = !busy[bsel];

  for (genvar b = 0; b < BANKS; b++) begin : g_start
    assign start[b] = req_valid && req_ready && (bsel == BSEL_W'(b));
  end
endmodule

// File: rtl/ilv_mem_rob.sv
module ilv_mem_rob
  import ilv_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 6,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int OCC_W = $clog2(SLOTS + 1);

  slot_state_e       state [SLOTS];
  logic [DATA_W-1:0] store [SLOTS];
  logic [TAG_W-1:0]  head, tail;
  logic [OCC_W-1:0]  occ;
  logic              pop;

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] x);
    return (x == TAG_W'(SLOTS - 1)) ? '0 : x + 1'b1;
  endfunction

  assign pop       = (state[head] == SLOT_DONE);
  assign alloc_tag = tail;

  // Data store: one write port from the banks, one read port at the head
  always_ff @(posedge clk) begin
    if (ret_valid) store[ret_tag] <= ret_data;
    if (pop)       rsp_data       <= store[head];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) state[i] <= SLOT_FREE;
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= pop;
      if (pop) begin
        state[head] <= SLOT_FREE;
        head        <= nxt(head);
      end
      if (ret_valid) state[ret_tag] <= SLOT_DONE;
      if (alloc) begin
        state[tail] <= SLOT_WAIT;
        tail        <= nxt(tail);
      end
      occ <= occ + OCC_W'(alloc) - OCC_W'(pop);
    end
  end

  // R9: a slot is only claimed while the store has room
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (occ < OCC_W'(SLOTS)));
  // R4: returned data always lands in a slot waiting for it
  assert_ret_wait_R4: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (state[ret_tag] == SLOT_WAIT));
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BANKS  = 8,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BSEL_W;
  localparam int SLOTS  = LAT + 2;
  localparam int TAG_W  = $clog2(SLOTS);

  logic [BANKS-1:0]  bank_busy;
  logic [BANKS-1:0]  bank_start;
  logic [BANKS-1:0]  bank_done;
  logic [TAG_W-1:0]  bank_tag  [BANKS];
  logic [DATA_W-1:0] bank_data [BANKS];
  logic [ROW_W-1:0]  row;
  logic [TAG_W-1:0]  alloc_tag;
  logic              alloc;
  logic              ret_valid;
  logic [TAG_W-1:0]  ret_tag;
  logic [DATA_W-1:0] ret_data;

  ilv_mem_steer #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .BSEL_W(BSEL_W), .ROW_W(ROW_W)
  ) u_steer (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .busy      (bank_busy),
    .req_ready (req_ready),
    .start     (bank_start),
    .row       (row)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ilv_mem_bank #(
      .ROW_W(ROW_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(LAT)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .start     (bank_start[b]),
      .wr        (req_write),
      .row       (row),
      .wdata     (req_wdata),
      .tag_in    (alloc_tag),
      .busy      (bank_busy[b]),
      .done      (bank_done[b]),
      .done_tag  (bank_tag[b]),
      .done_data (bank_data[b])
    );
  end

  // Completions are one-hot, so an OR of the masked buses forms the return
  always_comb begin
    ret_tag  = '0;
    ret_data = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_done[b]) begin
        ret_tag  = ret_tag  | bank_tag[b];
        ret_data = ret_data | bank_data[b];
      end
    end
  end
  assign ret_valid = |bank_done;
  assign alloc     = req_valid && req_ready && !req_write;

  ilv_mem_rob #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .TAG_W(TAG_W)
  ) u_rob (
    .clk       (clk),
    .rst       (rst),
    .alloc     (alloc),
    .alloc_tag (alloc_tag),
    .ret_valid (ret_valid),
    .ret_tag   (ret_tag),
    .ret_data  (ret_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R9: fixed latency and single issue give at most one completion per cycle
  assert_one_return_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_done));
  // R8: no response leaves in the first cycle after reset
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
  // R3: a stall is only ever caused by a busy bank
  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |-> (|bank_busy));
endmodule

// File: tb/sim_ilv_mem.sv
`timescale 1ns/1ps
module sim_ilv_mem;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BANKS  = 8;
  localparam int LAT    = 4;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr  = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  ilv_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int stalls = 0;
  int n_rsp = 0;
  int gap_mode = 0;
  int last_edge = 0;
  bit have_last = 1'b0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mdl [WORDS];
  logic [DATA_W-1:0] exp_data [$];
  int                exp_edge [$];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int a, input int salt);
    return DATA_W'((a * 32'h9E37) ^ (salt << 12) ^ 32'h5A00_0000);
  endfunction

  // Response monitor: order, data, latency and spacing
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_rsp++;
      if (exp_data.size() == 0) begin
        check(1'b0, "R5 response without a read", n_rsp, 0);
      end else begin
        logic [DATA_W-1:0] ed;
        int ee;
        ed = exp_data.pop_front();
        ee = exp_edge.pop_front();
        check(rsp_data === ed, "R4 read data", rsp_data, ed);
        check(cyc == ee + LAT + 1, "R2 read latency", cyc - ee, LAT + 1);
      end
      if (gap_mode != 0) begin
        if (have_last)
          check(cyc - last_edge == gap_mode,
                (gap_mode == 1) ? "R6 response spacing" : "R7 response spacing",
                cyc - last_edge, gap_mode);
        last_edge = cyc;
        have_last = 1'b1;
      end
    end
  end

  // Present one request and hold it until accepted
  task automatic issue(input bit wr, input int addr, input logic [DATA_W-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(addr);
    req_wdata = d;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    if (wr) mdl[addr] = d;
    else begin
      exp_data.push_back(mdl[addr]);
      exp_edge.push_back(cyc + 1);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'h1D5E_0042));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(req_ready === 1'b1, "R8 ready after reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R8 no response after reset", rsp_valid, 0);
    @(negedge clk);

    // Fill every word, sequentially (R6: no stall expected)
    s0 = stalls;
    for (int a = 0; a < WORDS; a++) issue(1'b1, a, pattern(a, 1));
    check(stalls == s0, "R6 sequential writes stall-free", stalls - s0, 0);
    idle(LAT + 4);
    check(n_rsp == 0, "R5 writes give no response", n_rsp, 0);

    // Sequential read stream: one word per cycle
    gap_mode = 1; have_last = 1'b0;
    s0 = stalls;
    for (int a = 0; a < 64; a++) issue(1'b0, (a + 16) % WORDS, 0);
    check(stalls == s0, "R6 sequential reads stall-free", stalls - s0, 0);
    idle(LAT + 6);
    gap_mode = 0;

    // Stride of BANKS: every access hits one bank
    gap_mode = LAT; have_last = 1'b0;
    s0 = stalls;
    for (int k = 0; k < 8; k++) issue(1'b0, 3 + k * BANKS, 0);
    check(stalls - s0 == 7 * (LAT - 1), "R7 stride stalls", stalls - s0, 7 * (LAT - 1));
    idle(LAT + 6);
    gap_mode = 0;

    // R1: upper bits alone share a bank, low bits alone do not
    s0 = stalls;
    issue(1'b0, 8'h00, 0);
    issue(1'b0, 8'h80, 0);
    check(stalls - s0 == LAT - 1, "R1 same bank by low bits", stalls - s0, LAT - 1);
    idle(LAT + 2);
    s0 = stalls;
    issue(1'b0, 8'h40, 0);
    issue(1'b0, 8'h41, 0);
    check(stalls == s0, "R1 distinct banks overlap", stalls - s0, 0);
    idle(LAT + 2);

    // R3: a write occupies its bank for the full latency
    s0 = stalls;
    issue(1'b1, 2, pattern(2, 7));
    issue(1'b0, 10, 0);
    check(stalls - s0 == LAT - 1, "R3 busy after write", stalls - s0, LAT - 1);
    issue(1'b0, 2, 0);
    idle(LAT + 4);

    // R5: a write-only burst to busy and free banks yields nothing
    s0 = n_rsp;
    for (int k = 0; k < 12; k++) issue(1'b1, (k * 5) % WORDS, pattern(k, 9));
    for (int k = 0; k < LAT + 4; k++) begin
      idle(1);
      #1;
      check(rsp_valid === 1'b0, "R5 no response for writes", rsp_valid, 0);
    end
    check(n_rsp == s0, "R5 response count unchanged", n_rsp - s0, 0);

    // Random mix with idle gaps
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 7));
      if (r == 0) idle(1);
      else issue(r < 3, int'($urandom_range(0, WORDS - 1)), $urandom());
    end
    idle(LAT + 8);
    check(exp_data.size() == 0, "R4 all reads answered", exp_data.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule